// File: doc/BRIEF.md
# Counting Logic Evaluator

This block computes one selectable logic function over a parameterized vector of digital inputs. The supported functions are OR, AND, odd parity, and three threshold tests that compare the number of high inputs against a configurable count n. An optional negate control inverts the result. The result appears on a combinational state line in the same cycle that the inputs change, so the line can feed further logic directly.

The block also keeps two banks of registered output lines. The normal bank takes the result and the inverse bank takes its complement. Both banks are written only on a cycle where the result differs from the level the block last tracked. Between such changes, each output bit can be overwritten through its own external write port. A one-cycle-per-change pulse marks every cycle in which the result differs from the tracked level.

A two-state machine holds the tracked level. `LVL_LOW` moves to `LVL_HIGH` on transition `RISE`, which happens when the result is high while the machine is in `LVL_LOW`. `LVL_HIGH` moves to `LVL_LOW` on transition `FALL`, which happens when the result is low while the machine is in `LVL_HIGH`. In every other case the machine stays in its state (transition `HOLD`). The configuration is loaded into a register at a clock edge when `cfg_we` is high.

Top module: `count_logic_eval`

## Requirements
- R1: After reset the configuration is function OR, n = 0 and negate off. The tracked level is low, every normal output is 0, every inverse output is 1, and with all inputs low both `state_line` and `change_pulse` are 0.
- R2: When `cfg_we` is high at a rising edge, `cfg_func`, `cfg_n` and `cfg_neg` are stored and take effect from that edge. The function codes are 0 = OR, 1 = AND, 2 = XOR, 3 = at-least-n, 4 = at-most-n and 5 = exactly-n. Codes 6 and 7 behave as OR.
- R3: OR is high when any input is high. AND is high only when all inputs are high.
- R4: XOR is high when the number of high inputs is odd.
- R5: With c as the number of high inputs, at-least-n is c >= n, at-most-n is c <= n and exactly-n is c == n. The value n = 0 is legal.
- R6: When negate is set, the function result is inverted before it reaches `state_line` and every other output.
- R7: `state_line` follows the current result combinationally, in the same cycle as an input change.
- R8: `change_pulse` is high in exactly the cycles where `state_line` differs from the tracked level. The tracked level takes the result at the next rising edge.
- R9: At the rising edge ending a change cycle, every bit of `out_q` is loaded with the result and every bit of `inv_q` with its complement.
- R10: When there is no change, an external write (`*_we` bit high) loads the matching `*_d` bit into that output. The value then holds until the next result change.
- R11: When a result change and an external write fall on the same edge, the result-change update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | N_IN | Digital inputs |
| cfg_we | input | 1 | Configuration load enable |
| cfg_func | input | 3 | Function code |
| cfg_n | input | CW | Count threshold n, CW = clog2(N_IN+1) |
| cfg_neg | input | 1 | Negate the result |
| state_line | output | 1 | Current result |
| change_pulse | output | 1 | Result differs from tracked level |
| out_q | output | N_OUT | Normal output registers |
| inv_q | output | N_INV | Inverse output registers |
| ext_out_we | input | N_OUT | External write enables, normal bank |
| ext_out_d | input | N_OUT | External write data, normal bank |
| ext_inv_we | input | N_INV | External write enables, inverse bank |
| ext_inv_d | input | N_INV | External write data, inverse bank |

## Verification
On every cycle, the assertions check the following:
- the population count never exceeds the input width;
- OR and AND agree with the all-zero and all-one input patterns;
- the tracked level moves only on a change cycle and then takes the result;
- both output banks load the result or its complement after a change;
- both banks hold when there is neither a change nor a write.

Only the bench scenarios can show the rest. These are the exact threshold arithmetic across every mode (including n = 0 and n = N_IN), the persistence of external overrides across many quiet cycles, and the priority of a change over a write on the same edge.

// File: rtl/count_logic_eval_pkg.sv
package count_logic_eval_pkg;

    typedef enum logic [2:0] {
        FN_OR      = 3'd0,
        FN_AND     = 3'd1,
        FN_XOR     = 3'd2,
        FN_ATLEAST = 3'd3,
        FN_ATMOST  = 3'd4,
        FN_EXACT   = 3'd5
    } func_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

endpackage

// File: rtl/cle_popcount.sv
module cle_popcount #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  din,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(din[i]);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= N); // R5

endmodule

// File: rtl/cle_func.sv
module cle_func
    import count_logic_eval_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  din,
    input  logic [CW-1:0] cnt,
    input  logic [2:0]    func,
    input  logic [CW-1:0] n_thr,
    input  logic          neg,
    output logic          res
);

    logic raw;

    always_comb begin
        unique case (func)
            FN_OR:      raw = |din;
            FN_AND:     raw = &din;
            FN_XOR:     raw = ^din;
            FN_ATLEAST: raw = (cnt >= n_thr);
            FN_ATMOST:  raw = (cnt <= n_thr);
            FN_EXACT:   raw = (cnt == n_thr);
            default:    raw = |din;
        endcase
        res = raw ^ neg;
    end

    AST_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_OR && cnt == '0) |-> (res == neg)); // R3
    AST_AND_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_AND && int'(cnt) == N) |-> (res == !neg)); // R3

endmodule

// File: rtl/cle_outreg.sv
module cle_outreg #(
    parameter int   W       = 2,
    parameter logic RST_VAL = 1'b0,
    parameter bit   INVERT  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         val,
    input  logic [W-1:0] ext_we,
    input  logic [W-1:0] ext_d,
    output logic [W-1:0] q
);

    localparam logic INV_BIT = INVERT ? 1'b1 : 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= RST_VAL;
            else if (upd)       q[i] <= val ^ INV_BIT;
            else if (ext_we[i]) q[i] <= ext_d[i];
        end
    end

    AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (q == {W{$past(val) ^ INV_BIT}})); // R9 R11
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && ext_we == '0) |=> $stable(q)); // R10

endmodule

// File: rtl/count_logic_eval.sv
module count_logic_eval
    import count_logic_eval_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 2,
    parameter int N_INV = 2,
    localparam int CW   = $clog2(N_IN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  din,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_func,
    input  logic [CW-1:0]    cfg_n,
    input  logic             cfg_neg,
    output logic             state_line,
    output logic             change_pulse,
    output logic [N_OUT-1:0] out_q,
    output logic [N_INV-1:0] inv_q,
    input  logic [N_OUT-1:0] ext_out_we,
    input  logic [N_OUT-1:0] ext_out_d,
    input  logic [N_INV-1:0] ext_inv_we,
    input  logic [N_INV-1:0] ext_inv_d
);

    logic [2:0]    func_q;
    logic [CW-1:0] n_q;
    logic          neg_q;
    logic [CW-1:0] cnt;
    logic          res;
    lvl_e          lvl_q, lvl_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= FN_OR;
            n_q    <= '0;
            neg_q  <= 1'b0;
        end else if (cfg_we) begin
            func_q <= cfg_func;
            n_q    <= cfg_n;
            neg_q  <= cfg_neg;
        end
    end

    cle_popcount #(.N(N_IN), .CW(CW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .din(din), .cnt(cnt)
    );

    cle_func #(.N(N_IN), .CW(CW)) i_func (
        .clk(clk), .rst_n(rst_n), .din(din), .cnt(cnt),
        .func(func_q), .n_thr(n_q), .neg(neg_q), .res(res)
    );

    // State register: tracked level
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_q <= lvl_d;
    end

    // Next state and outputs
    always_comb begin
        lvl_d        = lvl_q;
        change_pulse = 1'b0;
        unique case (lvl_q)
            LVL_LOW:  if (res)  begin lvl_d = LVL_HIGH; change_pulse = 1'b1; end
            LVL_HIGH: if (!res) begin lvl_d = LVL_LOW;  change_pulse = 1'b1; end
            default:  lvl_d = LVL_LOW;
        endcase
        state_line = res;
    end

    cle_outreg #(.W(N_OUT), .RST_VAL(1'b0), .INVERT(1'b0)) i_out (
        .clk(clk), .rst_n(rst_n), .upd(change_pulse), .val(res),
        .ext_we(ext_out_we), .ext_d(ext_out_d), .q(out_q)
    );

    cle_outreg #(.W(N_INV), .RST_VAL(1'b1), .INVERT(1'b1)) i_inv (
        .clk(clk), .rst_n(rst_n), .upd(change_pulse), .val(res),
        .ext_we(ext_inv_we), .ext_d(ext_inv_d), .q(inv_q)
    );

    AST_LVL_TAKES_RES: assert property (@(posedge clk) disable iff (!rst_n)
        change_pulse |=> (lvl_q == lvl_e'($past(state_line)))); // R8
    AST_LVL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !change_pulse |=> $stable(lvl_q)); // R8

endmodule

// File: tb/test_count_logic_eval.sv
module test_count_logic_eval;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 8;
    localparam int N_OUT = 2;
    localparam int N_INV = 2;
    localparam int CW    = $clog2(N_IN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  din = '0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_func = '0;
    logic [CW-1:0]    cfg_n = '0;
    logic             cfg_neg = 1'b0;
    logic             state_line, change_pulse;
    logic [N_OUT-1:0] out_q;
    logic [N_INV-1:0] inv_q;
    logic [N_OUT-1:0] ext_out_we = '0, ext_out_d = '0;
    logic [N_INV-1:0] ext_inv_we = '0, ext_inv_d = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    count_logic_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .N_INV(N_INV)) i_count_logic_eval (
        .clk(clk), .rst_n(rst_n), .din(din), .cfg_we(cfg_we), .cfg_func(cfg_func),
        .cfg_n(cfg_n), .cfg_neg(cfg_neg), .state_line(state_line),
        .change_pulse(change_pulse), .out_q(out_q), .inv_q(inv_q),
        .ext_out_we(ext_out_we), .ext_out_d(ext_out_d),
        .ext_inv_we(ext_inv_we), .ext_inv_d(ext_inv_d)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic ref_res(input logic [N_IN-1:0] v, input int f,
                                     input int n, input logic ng);
        int c = $countones(v);
        logic r;
        case (f)
            1: r = (c == N_IN);
            2: r = c[0];
            3: r = (c >= n);
            4: r = (c <= n);
            5: r = (c == n);
            default: r = (c != 0);
        endcase
        return r ^ ng;
    endfunction

    task automatic set_cfg(input int f, input int n, input logic ng);
        @(negedge clk);
        cfg_func = f[2:0]; cfg_n = n[CW-1:0]; cfg_neg = ng; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Apply inputs at a negedge, settle two edges so level and outputs follow
    task automatic settle(input logic [N_IN-1:0] v);
        @(negedge clk); din = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(state_line == 1'b0, "R1 state_line", int'(state_line), 0);
        check(change_pulse == 1'b0, "R1 change_pulse", int'(change_pulse), 0);
        check(out_q == '0, "R1 out_q", int'(out_q), 0);
        check(inv_q == '1, "R1 inv_q", int'(inv_q), 3);
        @(negedge clk); din = 8'h10; #1;
        check(state_line == 1'b1, "R1 default OR", int'(state_line), 1);
        settle('0);
    endtask

    task automatic t_modes;
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 3; k++) begin
                int n = (k == 0) ? 0 : (k == 1) ? N_IN : int'($urandom_range(1, N_IN - 1));
                set_cfg(f, n, 1'b0);
                for (int j = 0; j < 24; j++) begin
                    logic [N_IN-1:0] v;
                    logic e;
                    v = (j == 0) ? '0 : (j == 1) ? '1 : N_IN'($urandom);
                    @(negedge clk); din = v; #1;
                    e = ref_res(v, f, n, 1'b0);
                    if (f == 0 || f == 1 || f > 5)
                        check(state_line == e, "R3 R2 or/and/alias", int'(state_line), int'(e));
                    else if (f == 2)
                        check(state_line == e, "R4 xor", int'(state_line), int'(e));
                    else
                        check(state_line == e, "R5 count mode", int'(state_line), int'(e));
                end
            end
        end
        set_cfg(0, 0, 1'b0);
        settle('0);
    endtask

    task automatic t_negate;
        set_cfg(3, 3, 1'b1);
        for (int j = 0; j < 16; j++) begin
            logic [N_IN-1:0] v = N_IN'($urandom);
            logic e = ref_res(v, 3, 3, 1'b1);
            @(negedge clk); din = v; #1;
            check(state_line == e, "R6 negate", int'(state_line), int'(e));
        end
        set_cfg(0, 0, 1'b0);
        settle('0);
    endtask

    task automatic t_update;
        @(negedge clk); din = 8'h01; #1;
        check(state_line == 1'b1, "R7 same-cycle result", int'(state_line), 1);
        check(change_pulse == 1'b1, "R8 pulse on change", int'(change_pulse), 1);
        check(out_q == '0, "R9 not yet loaded", int'(out_q), 0);
        @(negedge clk);
        check(change_pulse == 1'b0, "R8 pulse drops", int'(change_pulse), 0);
        check(out_q == '1, "R9 out_q loaded", int'(out_q), 3);
        check(inv_q == '0, "R9 inv_q loaded", int'(inv_q), 0);
        @(negedge clk); din = 8'h03; #1;
        check(change_pulse == 1'b0, "R8 no pulse same result", int'(change_pulse), 0);
        settle('0);
        check(out_q == '0 && inv_q == '1, "R9 falls back", int'({out_q, inv_q}), 3);
    endtask

    task automatic t_override;
        @(negedge clk);
        ext_out_we = 2'b01; ext_out_d = 2'b01; ext_inv_we = 2'b10; ext_inv_d = 2'b00;
        @(negedge clk);
        ext_out_we = '0; ext_inv_we = '0;
        check(out_q == 2'b01, "R10 out write", int'(out_q), 1);
        check(inv_q == 2'b01, "R10 inv write", int'(inv_q), 1);
        din = 8'h00;
        for (int j = 0; j < 5; j++) @(negedge clk);
        check(out_q == 2'b01 && inv_q == 2'b01, "R10 persists", int'({out_q, inv_q}), 5);
        din = 8'h80;
        @(negedge clk);
        check(out_q == 2'b11 && inv_q == 2'b00, "R10 next change overwrites",
              int'({out_q, inv_q}), 12);
    endtask

    task automatic t_collide;
        @(negedge clk);
        din = 8'h00; ext_out_we = '1; ext_out_d = '1; ext_inv_we = '1; ext_inv_d = '0;
        #1;
        check(change_pulse == 1'b1, "R11 change present", int'(change_pulse), 1);
        @(negedge clk);
        ext_out_we = '0; ext_inv_we = '0;
        check(out_q == '0 && inv_q == '1, "R11 change wins", int'({out_q, inv_q}), 3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_negate();
        t_update();
        t_override();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule